// File: doc/BRIEF.md
# Multicycle Instruction Phase Sequencer

This block is the control unit of a small multicycle processor built around one shared bus. It takes the instruction register contents and a memory-ready handshake. Each clock cycle it produces the full set of datapath controls: which source drives the bus, which registers load, the multiplexer selects, the ALU operation, the memory read and write strobes, the register-file addresses and the sign-extended immediate or offset. Every instruction passes through an ordered set of phases: fetch, decode, address evaluation, operand fetch, execute and result store. A phase that an opcode does not need is left out.

Four opcodes are handled: register add (with a register or immediate second operand), base-plus-offset load, base-plus-offset store, and unconditional PC-relative branch. Any other opcode goes back to fetch after decode and issues no load, no memory access and no PC change. The datapath reads the current phase on a small output so that it can be traced.

Top module: `phase_seq`

## Requirements
- R1: Reset is synchronous and active low. It places the sequencer in the first fetch step. In that step `bus_drv` is 4'b0001 (PC on the bus), `ld_mar` and `ld_pc` are 1, `pc_sel` is 0 (incrementer), `mem_en` is 0 and `phase` is 0 (fetch). A reset asserted in the middle of an instruction returns the sequencer to this step on the next edge.
- R2: The second fetch step holds `mem_en`=1 and `mdr_sel`=1 (memory) until `mem_ready` is 1. `ld_mdr` is high only in the cycle where `mem_ready` is 1. The third step drives the MDR on the bus (`bus_drv`=4'b0100) with `ld_ir`=1, and decode (`phase`=1) follows.
- R3: The opcode is `ir[15:12]`, with ADD=4'h1, LDR=4'h6, STR=4'h7 and BR=4'h0. The decode cycle drives no bus and asserts no load or memory strobe. For any other opcode the cycle after decode is the first fetch step.
- R4: ADD spends one execute cycle (`phase`=4). In that cycle `alu_op`=0 (add), the ALU drives the bus (4'b1000), `ld_reg` and `ld_cc` are 1, `dr`=`ir[11:9]`, `sr1`=`ir[8:6]`, `sr2`=`ir[2:0]` and `op2_imm`=`ir[5]`. `imm_ext` is `ir[4:0]` sign-extended to 16 bits.
- R5: LDR and STR have one address cycle (`phase`=2). In that cycle `addr1_sel`=1 (base register `sr1`=`ir[8:6]`), `addr2_sel`=1 and `imm_ext` is `ir[5:0]` sign-extended. The address adder drives the bus (4'b0010) and `ld_mar`=1.
- R6: LDR then reads memory (`phase`=3, `mem_en`=1, `mem_we`=0) until ready. A write-back cycle follows with the MDR on the bus, `ld_reg`=1 and `ld_cc`=1.
- R7: STR then runs a cycle with `sr1`=`ir[11:9]`, `alu_op`=3 (pass), the ALU on the bus, `ld_mdr`=1 and `mdr_sel`=0. After it, `mem_en` and `mem_we` stay at 1 until ready. Neither `ld_reg` nor `ld_cc` is asserted.
- R8: BR takes one cycle with `pc_sel`=1 (adder), `addr1_sel`=0 (PC), `addr2_sel`=2, `imm_ext` equal to `ir[8:0]` sign-extended, `ld_pc`=1 and no bus driver.
- R9: No cycle has more than one bus driver. Every cycle that loads the MAR, IR or a register, or loads the MDR from the bus, has exactly one driver.
- R10: `ld_cc` equals `ld_reg` in every cycle.
- R11: A cycle with `mem_en`=1 and `mem_ready`=0 is followed by a cycle with the same `phase`, the same `mem_we` and `mem_en` still 1.
- R12: With w wait cycles per memory access, each instruction takes the following number of cycles from first fetch step to the next first fetch step: ADD and BR take 5+w, LDR and STR take 7+2w, and other opcodes take 4+w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir | input | 16 | Instruction register contents |
| mem_ready | input | 1 | Memory has completed the current access |
| bus_drv | output | 4 | Bus drive enables: bit0 PC, bit1 address adder, bit2 MDR, bit3 ALU |
| ld_mar | output | 1 | MAR load enable |
| ld_mdr | output | 1 | MDR load enable |
| ld_ir | output | 1 | IR load enable |
| ld_pc | output | 1 | PC load enable |
| ld_reg | output | 1 | Register file write enable |
| ld_cc | output | 1 | Condition code load enable |
| pc_sel | output | 2 | PC source: 0 incrementer, 1 adder, 2 bus |
| addr1_sel | output | 1 | Adder base: 0 PC, 1 register sr1 |
| addr2_sel | output | 2 | Adder offset: 0 zero, 1 six-bit, 2 nine-bit, 3 eleven-bit |
| mdr_sel | output | 1 | MDR source: 0 bus, 1 memory |
| op2_imm | output | 1 | ALU second operand: 1 immediate, 0 register sr2 |
| alu_op | output | 2 | 0 add, 1 and, 2 not, 3 pass |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write strobe |
| dr | output | 3 | Destination register address |
| sr1 | output | 3 | First source register address |
| sr2 | output | 3 | Second source register address |
| imm_ext | output | 16 | Sign-extended immediate or offset for the current step |
| phase | output | 3 | 0 fetch, 1 decode, 2 address, 3 operand, 4 execute, 5 store |

## Verification
Every control output is a combinational function of the registered state, plus `ir` fields and `mem_ready`. A step's controls are therefore valid for the whole cycle after the edge that enters the step, and the next step is due one edge later, or one edge after `mem_ready` rises in a waiting step. The bench applies `ir` and `mem_ready` at the falling edge and samples one time unit later. Its memory model raises `mem_ready` after exactly w sampled cycles of `mem_en`. This lets the cycle counts in R12 be predicted exactly: a single table walk counts cycles and strobes per instruction, and directed traces check each step's controls in the cycle that step is expected to occupy.

// File: rtl/seq_pkg.sv
// Package: shared widths, encodings, states and the control word of the
// phase sequencer. Assumes a 16-bit instruction with a 4-bit opcode on top.
package seq_pkg;
    localparam int IR_W     = 16;
    localparam int OPC_W    = 4;
    localparam int OPC_LSB  = IR_W - OPC_W;
    localparam int RA_W     = 3;
    localparam int NUM_OPS  = 1 << OPC_W;
    localparam int BUS_SRCS = 4;

    // opcode values (index into the one-hot decode)
    localparam int OPC_BR  = 0;
    localparam int OPC_ADD = 1;
    localparam int OPC_LDR = 6;
    localparam int OPC_STR = 7;

    // bus source bit positions
    localparam int BUS_PC  = 0;
    localparam int BUS_ADR = 1;
    localparam int BUS_MDR = 2;
    localparam int BUS_ALU = 3;

    localparam logic [1:0] PCS_INC   = 2'd0;
    localparam logic [1:0] PCS_ADDER = 2'd1;
    localparam logic [1:0] PCS_BUS   = 2'd2;

    localparam logic       A1_PC  = 1'b0;
    localparam logic       A1_REG = 1'b1;
    localparam logic [1:0] A2_ZERO  = 2'd0;
    localparam logic [1:0] A2_OFF6  = 2'd1;
    localparam logic [1:0] A2_OFF9  = 2'd2;
    localparam logic [1:0] A2_OFF11 = 2'd3;

    localparam logic MDR_BUS = 1'b0;
    localparam logic MDR_MEM = 1'b1;

    localparam logic [1:0] ALU_ADD  = 2'd0;
    localparam logic [1:0] ALU_AND  = 2'd1;
    localparam logic [1:0] ALU_NOT  = 2'd2;
    localparam logic [1:0] ALU_PASS = 2'd3;

    localparam logic [1:0] IMM_NONE = 2'd0;
    localparam logic [1:0] IMM_5    = 2'd1;
    localparam logic [1:0] IMM_6    = 2'd2;
    localparam logic [1:0] IMM_9    = 2'd3;

    typedef enum logic [3:0] {
        S_F1, S_F2, S_F3, S_DEC, S_EA, S_LD_RD, S_LD_WB,
        S_ST_MDR, S_ST_WR, S_ADD, S_BR
    } state_t;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EVAL   = 3'd2,
        PH_OPER   = 3'd3,
        PH_EXEC   = 3'd4,
        PH_STORE  = 3'd5
    } phase_t;

    typedef struct packed {
        logic [BUS_SRCS-1:0] bus_drv;
        logic                ld_mar;
        logic                ld_mdr;
        logic                ld_ir;
        logic                ld_pc;
        logic                ld_reg;
        logic                ld_cc;
        logic [1:0]          pc_sel;
        logic                addr1_sel;
        logic [1:0]          addr2_sel;
        logic                mdr_sel;
        logic [1:0]          alu_op;
        logic                mem_en;
        logic                mem_we;
        logic                sr1_hi;
        logic [1:0]          imm_kind;
        phase_t              phase;
    } ctrl_t;
endpackage

// File: rtl/seq_opdec.sv
// Module: one-hot opcode decoder. Output bit i is high when the code equals i.
// Assumes IN_W is small (output width is 2**IN_W).
module seq_opdec #(
    parameter int IN_W = 4,
    localparam int OUT_W = 1 << IN_W
) (
    input  logic [IN_W-1:0]  code,
    output logic [OUT_W-1:0] hot
);
    // one comparator per output line
    for (genvar i = 0; i < OUT_W; i++) begin : g_line
        assign hot[i] = (code == IN_W'(i));
    end
endmodule

// File: rtl/seq_state.sv
// Module: state register and next-state logic. Chooses the path of each
// instruction from the one-hot opcode and holds memory steps until ready.
// Assumes the opcode lines are valid in the decode and address steps.
module seq_state
    import seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OPS-1:0] op_hot,
    input  logic               mem_ready,
    output state_t             state
);
    localparam logic [NUM_OPS-1:0] SUPPORTED =
        (NUM_OPS'(1) << OPC_BR) | (NUM_OPS'(1) << OPC_ADD) |
        (NUM_OPS'(1) << OPC_LDR) | (NUM_OPS'(1) << OPC_STR);

    logic   known;
    state_t nxt;

    // opcode is one the sequencer implements
    assign known = |(op_hot & SUPPORTED);

    // next step selection
    always_comb begin
        nxt = S_F1;
        unique case (state)
            S_F1:     nxt = S_F2;
            S_F2:     nxt = mem_ready ? S_F3 : S_F2;
            S_F3:     nxt = S_DEC;
            S_DEC: begin
                if (!known)               nxt = S_F1;
                else if (op_hot[OPC_ADD]) nxt = S_ADD;
                else if (op_hot[OPC_BR])  nxt = S_BR;
                else                      nxt = S_EA;
            end
            S_EA:     nxt = op_hot[OPC_STR] ? S_ST_MDR : S_LD_RD;
            S_LD_RD:  nxt = mem_ready ? S_LD_WB : S_LD_RD;
            S_LD_WB:  nxt = S_F1;
            S_ST_MDR: nxt = S_ST_WR;
            S_ST_WR:  nxt = mem_ready ? S_F1 : S_ST_WR;
            S_ADD:    nxt = S_F1;
            S_BR:     nxt = S_F1;
            default:  nxt = S_F1;
        endcase
    end

    // state register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_F1;
        else        state <= nxt;
    end
endmodule

// File: rtl/seq_ctrl.sv
// Module: control word for each step. Purely combinational from the state
// and the memory-ready handshake. Assumes default values mean "no action".
module seq_ctrl
    import seq_pkg::*;
(
    input  state_t state,
    input  logic   mem_ready,
    output ctrl_t  c
);
    // per-step register transfer controls
    always_comb begin
        c       = '0;
        c.phase = PH_FETCH;
        unique case (state)
            S_F1: begin
                c.bus_drv[BUS_PC] = 1'b1;
                c.ld_mar = 1'b1;
                c.ld_pc  = 1'b1;
                c.pc_sel = PCS_INC;
            end
            S_F2: begin
                c.mem_en  = 1'b1;
                c.mdr_sel = MDR_MEM;
                c.ld_mdr  = mem_ready;
            end
            S_F3: begin
                c.bus_drv[BUS_MDR] = 1'b1;
                c.ld_ir = 1'b1;
            end
            S_DEC: c.phase = PH_DECODE;
            S_EA: begin
                c.phase     = PH_EVAL;
                c.addr1_sel = A1_REG;
                c.addr2_sel = A2_OFF6;
                c.imm_kind  = IMM_6;
                c.bus_drv[BUS_ADR] = 1'b1;
                c.ld_mar    = 1'b1;
            end
            S_LD_RD: begin
                c.phase   = PH_OPER;
                c.mem_en  = 1'b1;
                c.mdr_sel = MDR_MEM;
                c.ld_mdr  = mem_ready;
            end
            S_LD_WB: begin
                c.phase  = PH_STORE;
                c.bus_drv[BUS_MDR] = 1'b1;
                c.ld_reg = 1'b1;
                c.ld_cc  = 1'b1;
            end
            S_ST_MDR: begin
                c.phase   = PH_STORE;
                c.sr1_hi  = 1'b1;
                c.alu_op  = ALU_PASS;
                c.bus_drv[BUS_ALU] = 1'b1;
                c.ld_mdr  = 1'b1;
                c.mdr_sel = MDR_BUS;
            end
            S_ST_WR: begin
                c.phase  = PH_STORE;
                c.mem_en = 1'b1;
                c.mem_we = 1'b1;
            end
            S_ADD: begin
                c.phase    = PH_EXEC;
                c.alu_op   = ALU_ADD;
                c.imm_kind = IMM_5;
                c.bus_drv[BUS_ALU] = 1'b1;
                c.ld_reg   = 1'b1;
                c.ld_cc    = 1'b1;
            end
            S_BR: begin
                c.phase     = PH_EXEC;
                c.pc_sel    = PCS_ADDER;
                c.addr1_sel = A1_PC;
                c.addr2_sel = A2_OFF9;
                c.imm_kind  = IMM_9;
                c.ld_pc     = 1'b1;
            end
            default: c.phase = PH_FETCH;
        endcase
    end
endmodule

// File: rtl/phase_seq.sv
// Module: top of the multicycle phase sequencer. Decodes the opcode, steps
// the state machine and drives the datapath controls, register addresses
// and sign-extended immediates. Assumes ir holds the IR register's value.
module phase_seq
    import seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IR_W-1:0]     ir,
    input  logic                mem_ready,
    output logic [BUS_SRCS-1:0] bus_drv,
    output logic                ld_mar,
    output logic                ld_mdr,
    output logic                ld_ir,
    output logic                ld_pc,
    output logic                ld_reg,
    output logic                ld_cc,
    output logic [1:0]          pc_sel,
    output logic                addr1_sel,
    output logic [1:0]          addr2_sel,
    output logic                mdr_sel,
    output logic                op2_imm,
    output logic [1:0]          alu_op,
    output logic                mem_en,
    output logic                mem_we,
    output logic [RA_W-1:0]     dr,
    output logic [RA_W-1:0]     sr1,
    output logic [RA_W-1:0]     sr2,
    output logic [IR_W-1:0]     imm_ext,
    output logic [2:0]          phase
);
    logic [NUM_OPS-1:0] op_hot;
    state_t             state;
    ctrl_t              c;

    seq_opdec #(.IN_W(OPC_W)) u_dec (
        .code (ir[IR_W-1:OPC_LSB]),
        .hot  (op_hot)
    );

    seq_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_hot    (op_hot),
        .mem_ready (mem_ready),
        .state     (state)
    );

    seq_ctrl u_ctrl (
        .state     (state),
        .mem_ready (mem_ready),
        .c         (c)
    );

    // control word fan-out
    assign bus_drv   = c.bus_drv;
    assign ld_mar    = c.ld_mar;
    assign ld_mdr    = c.ld_mdr;
    assign ld_ir     = c.ld_ir;
    assign ld_pc     = c.ld_pc;
    assign ld_reg    = c.ld_reg;
    assign ld_cc     = c.ld_cc;
    assign pc_sel    = c.pc_sel;
    assign addr1_sel = c.addr1_sel;
    assign addr2_sel = c.addr2_sel;
    assign mdr_sel   = c.mdr_sel;
    assign alu_op    = c.alu_op;
    assign mem_en    = c.mem_en;
    assign mem_we    = c.mem_we;
    assign phase     = c.phase;

    // register addresses from fixed IR fields
    assign dr      = ir[11:9];
    assign sr1     = c.sr1_hi ? ir[11:9] : ir[8:6];
    assign sr2     = ir[2:0];
    assign op2_imm = ir[5];

    // sign-extended immediate for the current step
    always_comb begin
        unique case (c.imm_kind)
            IMM_5:   imm_ext = {{(IR_W-5){ir[4]}}, ir[4:0]};
            IMM_6:   imm_ext = {{(IR_W-6){ir[5]}}, ir[5:0]};
            IMM_9:   imm_ext = {{(IR_W-9){ir[8]}}, ir[8:0]};
            default: imm_ext = '0;
        endcase
    end
endmodule

// File: rtl/phase_seq_chk.sv
// Module: protocol checker for the phase sequencer, bound to every instance.
module phase_seq_chk
    import seq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                mem_ready,
    input logic [BUS_SRCS-1:0] bus_drv,
    input logic                ld_mar,
    input logic                ld_mdr,
    input logic                ld_ir,
    input logic                ld_pc,
    input logic                ld_reg,
    input logic                ld_cc,
    input logic [1:0]          pc_sel,
    input logic                mdr_sel,
    input logic                mem_en,
    input logic                mem_we,
    input logic [2:0]          phase
);
    AST_BUS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_drv)); // R9
    AST_LOAD_HAS_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mar || ld_ir || ld_reg || (ld_mdr && mdr_sel == MDR_BUS))
        |-> ($countones(bus_drv) == 1)); // R9
    AST_CC_TRACKS_REG: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cc == ld_reg); // R10
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_ready) |=> (mem_en && $stable(mem_we) && $stable(phase))); // R11
    AST_IR_THEN_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ir |=> (phase == 3'(PH_DECODE))); // R2
    AST_MDR_MEM_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mdr && mdr_sel == MDR_MEM) |-> (mem_ready && mem_en)); // R2
    AST_WRITE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en); // R7
    AST_JUMP_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pc && pc_sel == PCS_ADDER) |-> (bus_drv == '0)); // R8
endmodule

bind phase_seq phase_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_ready (mem_ready),
    .bus_drv   (bus_drv),
    .ld_mar    (ld_mar),
    .ld_mdr    (ld_mdr),
    .ld_ir     (ld_ir),
    .ld_pc     (ld_pc),
    .ld_reg    (ld_reg),
    .ld_cc     (ld_cc),
    .pc_sel    (pc_sel),
    .mdr_sel   (mdr_sel),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .phase     (phase)
);

// File: tb/phase_seq_tb.sv
module phase_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ir = 16'h0000;
    logic        mem_ready = 1'b0;
    logic [3:0]  bus_drv;
    logic        ld_mar, ld_mdr, ld_ir, ld_pc, ld_reg, ld_cc;
    logic [1:0]  pc_sel, addr2_sel, alu_op;
    logic        addr1_sel, mdr_sel, op2_imm, mem_en, mem_we;
    logic [2:0]  dr, sr1, sr2, phase;
    logic [15:0] imm_ext;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] pend_ir = 16'h0000;
    int cur_w = 0;
    int wait_cnt = 0;
    int multi_drv = 0;
    int cc_mismatch = 0;

    always #5 clk = ~clk;

    phase_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ir(ir), .mem_ready(mem_ready),
        .bus_drv(bus_drv), .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_ir(ld_ir),
        .ld_pc(ld_pc), .ld_reg(ld_reg), .ld_cc(ld_cc), .pc_sel(pc_sel),
        .addr1_sel(addr1_sel), .addr2_sel(addr2_sel), .mdr_sel(mdr_sel),
        .op2_imm(op2_imm), .alu_op(alu_op), .mem_en(mem_en), .mem_we(mem_we),
        .dr(dr), .sr1(sr1), .sr2(sr2), .imm_ext(imm_ext), .phase(phase)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one clock: IR register model and memory model, sample after negedge
    task automatic tick();
        bit load_ir;
        load_ir = ld_ir;
        @(posedge clk);
        @(negedge clk);
        if (load_ir) ir = pend_ir;
        if (mem_en) begin
            mem_ready = (wait_cnt >= cur_w);
            wait_cnt++;
        end else begin
            mem_ready = 1'b0;
            wait_cnt = 0;
        end
        #1;
    endtask

    function automatic bit at_fetch1();
        return bus_drv == 4'b0001 && ld_mar && ld_pc && pc_sel == 2'd0;
    endfunction

    // step from the first fetch step until decode is reached
    task automatic to_decode();
        for (int k = 0; k < 40; k++) begin
            if (phase == 3'd1) break;
            tick();
        end
    endtask

    task automatic run_instr(input logic [15:0] instr, input int w,
                             output int cyc, output int nreg, output int nwe,
                             output int ncc, output int npc);
        pend_ir = instr;
        cur_w = w;
        cyc = 0; nreg = 0; nwe = 0; ncc = 0; npc = 0;
        for (int k = 0; k < 60; k++) begin
            nreg += int'(ld_reg);
            nwe  += int'(mem_we);
            ncc  += int'(ld_cc);
            npc  += int'(ld_pc);
            if ($countones(bus_drv) > 1) multi_drv++;
            if (ld_cc != ld_reg) cc_mismatch++;
            tick();
            cyc++;
            if (at_fetch1()) break;
        end
    endtask

    // {ir, wait, cycles, reg loads, write cycles, cc loads, pc loads}
    localparam int NV = 8;
    localparam logic [43:0] VEC [NV] = '{
        {16'h1283, 4'd0, 8'd5,  4'd1, 4'd0, 4'd1, 4'd1},
        {16'h127F, 4'd2, 8'd7,  4'd1, 4'd0, 4'd1, 4'd1},
        {16'h6A85, 4'd0, 8'd7,  4'd1, 4'd0, 4'd1, 4'd1},
        {16'h6A85, 4'd3, 8'd13, 4'd1, 4'd0, 4'd1, 4'd1},
        {16'h7C42, 4'd1, 8'd9,  4'd0, 4'd2, 4'd0, 4'd1},
        {16'h0E05, 4'd0, 8'd5,  4'd0, 4'd0, 4'd0, 4'd2},
        {16'hF025, 4'd0, 8'd4,  4'd0, 4'd0, 4'd0, 4'd1},
        {16'h2000, 4'd2, 8'd6,  4'd0, 4'd0, 4'd0, 4'd1}
    };

    initial begin
        int cyc, nreg, nwe, ncc, npc;
        // R1 reset state
        repeat (3) tick();
        chk(phase == 3'd0, "R1", "reset phase", phase, 0);
        chk(bus_drv == 4'b0001, "R1", "reset bus_drv", bus_drv, 4'b0001);
        chk(ld_mar && ld_pc && pc_sel == 2'd0 && !mem_en, "R1", "reset fetch controls",
            {ld_mar, ld_pc, pc_sel, mem_en}, 5'b11000);
        rst_n = 1'b1;

        // table walk: R12 cycle counts and strobe counts
        for (int v = 0; v < NV; v++) begin
            logic [43:0] e;
            e = VEC[v];
            run_instr(e[43:28], int'(e[27:24]), cyc, nreg, nwe, ncc, npc);
            chk(cyc == int'(e[23:16]), "R12", $sformatf("cycles vec%0d", v), cyc, e[23:16]);
            chk(nreg == int'(e[15:12]), "R4/R6/R3", $sformatf("reg loads vec%0d", v), nreg, e[15:12]);
            chk(nwe == int'(e[11:8]), "R7", $sformatf("write cycles vec%0d", v), nwe, e[11:8]);
            chk(ncc == int'(e[7:4]), "R10", $sformatf("cc loads vec%0d", v), ncc, e[7:4]);
            chk(npc == int'(e[3:0]), "R8", $sformatf("pc loads vec%0d", v), npc, e[3:0]);
        end
        chk(multi_drv == 0, "R9", "cycles with several bus drivers", multi_drv, 0);
        chk(cc_mismatch == 0, "R10", "ld_cc differs from ld_reg", cc_mismatch, 0);

        // R2 / R4 directed: ADD immediate with one wait cycle
        pend_ir = 16'h127F; cur_w = 1;
        tick();
        chk(mem_en && !mem_we && !mem_ready && !ld_mdr, "R2", "fetch wait",
            {mem_en, mem_we, mem_ready, ld_mdr}, 4'b1000);
        tick();
        chk(mem_ready && ld_mdr && mdr_sel && phase == 3'd0, "R2", "fetch read done",
            {mem_ready, ld_mdr, mdr_sel, phase}, 6'b111000);
        tick();
        chk(bus_drv == 4'b0100 && ld_ir, "R2", "IR load step", {bus_drv, ld_ir}, 5'b01001);
        tick();
        chk(phase == 3'd1 && bus_drv == 0 && !ld_mar && !ld_reg && !mem_en, "R3", "decode idle",
            {phase, bus_drv, ld_mar, ld_reg, mem_en}, {3'd1, 7'd0});
        tick();
        chk(phase == 3'd4 && alu_op == 2'd0 && bus_drv == 4'b1000 && ld_reg && ld_cc,
            "R4", "ADD execute", {phase, alu_op, bus_drv, ld_reg, ld_cc}, {3'd4, 2'd0, 4'b1000, 2'b11});
        chk(dr == 3'd1 && sr1 == 3'd1 && sr2 == 3'd7 && op2_imm && imm_ext == 16'hFFFF,
            "R4", "ADD fields", {dr, sr1, sr2, op2_imm, imm_ext}, {3'd1, 3'd1, 3'd7, 1'b1, 16'hFFFF});
        tick();
        chk(at_fetch1(), "R4", "back to fetch after ADD", bus_drv, 4'b0001);

        // R5 / R6 / R11 / R1: LDR, stall, reset mid-access
        pend_ir = 16'h6A85; cur_w = 0;
        to_decode();
        cur_w = 3;
        tick();
        chk(phase == 3'd2 && addr1_sel && addr2_sel == 2'd1 && bus_drv == 4'b0010 && ld_mar,
            "R5", "LDR address step", {phase, addr1_sel, addr2_sel, bus_drv, ld_mar},
            {3'd2, 1'b1, 2'd1, 4'b0010, 1'b1});
        chk(sr1 == 3'd2 && imm_ext == 16'h0005, "R5", "LDR base and offset", {sr1, imm_ext}, {3'd2, 16'h0005});
        tick();
        chk(phase == 3'd3 && mem_en && !mem_we && !mem_ready, "R6", "LDR read waiting",
            {phase, mem_en, mem_we, mem_ready}, {3'd3, 3'b100});
        tick();
        chk(phase == 3'd3 && mem_en && !ld_reg, "R11", "LDR read held", {phase, mem_en, ld_reg}, {3'd3, 2'b10});
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk(at_fetch1() && !mem_en, "R1", "reset mid-instruction", {bus_drv, mem_en}, 5'b00010);

        // R6 write-back with zero wait
        pend_ir = 16'h6A85; cur_w = 0;
        to_decode();
        tick(); tick(); tick();
        chk(phase == 3'd5 && bus_drv == 4'b0100 && ld_reg && ld_cc && dr == 3'd5,
            "R6", "LDR write-back", {phase, bus_drv, ld_reg, ld_cc, dr}, {3'd5, 4'b0100, 2'b11, 3'd5});
        tick();

        // R7 STR
        pend_ir = 16'h7C7E; cur_w = 0;
        to_decode();
        tick();
        chk(sr1 == 3'd1 && imm_ext == 16'hFFFE && ld_mar, "R5", "STR address", {sr1, imm_ext, ld_mar},
            {3'd1, 16'hFFFE, 1'b1});
        tick();
        chk(sr1 == 3'd6 && alu_op == 2'd3 && bus_drv == 4'b1000 && ld_mdr && !mdr_sel && !ld_reg,
            "R7", "STR MDR load", {sr1, alu_op, bus_drv, ld_mdr, mdr_sel, ld_reg},
            {3'd6, 2'd3, 4'b1000, 3'b100});
        tick();
        chk(mem_en && mem_we && !ld_reg && !ld_cc, "R7", "STR write", {mem_en, mem_we, ld_reg, ld_cc}, 4'b1100);
        tick();
        chk(at_fetch1(), "R7", "back to fetch after STR", bus_drv, 4'b0001);

        // R8 branch with negative offset
        pend_ir = 16'h0F00; cur_w = 0;
        to_decode();
        tick();
        chk(pc_sel == 2'd1 && !addr1_sel && addr2_sel == 2'd2 && ld_pc && bus_drv == 0 &&
            imm_ext == 16'hFF00, "R8", "branch step", {pc_sel, addr1_sel, addr2_sel, ld_pc, bus_drv, imm_ext},
            {2'd1, 1'b0, 2'd2, 1'b1, 4'd0, 16'hFF00});
        tick();
        chk(at_fetch1(), "R8", "back to fetch after BR", bus_drv, 4'b0001);

        // R3 unimplemented opcode touches nothing
        pend_ir = 16'hB123; cur_w = 0;
        to_decode();
        chk(!ld_reg && !ld_pc && !ld_mar && !ld_mdr && !mem_en && bus_drv == 0, "R3",
            "decode of unknown opcode idle", {ld_reg, ld_pc, ld_mar, ld_mdr, mem_en, bus_drv}, 0);
        tick();
        chk(at_fetch1(), "R3", "unknown opcode returns to fetch", bus_drv, 4'b0001);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule